// File: doc/BRIEF.md
# Packet-Referenced Oscillator Trim Controller

This block keeps an internal oscillator, nominally at 24 MHz, on frequency by using received low-speed USB traffic as the timing reference. A decoder upstream marks the start and the end of a span of known length inside each received packet. The block counts oscillator cycles across that span and compares the count with the expected value. It then moves a 4-bit coarse trim code or a 6-bit fine trim code by one step toward the target.

A coarse search pulls the oscillator into range first, and single fine steps then hold it there. When the fine-only control is set, coarse steps are suppressed, so the oscillator frequency only changes in small increments once it is tuned. When the disable control is set, the trim is frozen and any reference events that arrive are dropped. A locked flag reports that recent measurements have been inside the ±1.5% window. A higher code value is taken to mean a higher oscillator frequency. A count above the expected value therefore lowers the code.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, coarse_o is 8 (the coarse midpoint), fine_o is 32 (the fine midpoint) and locked_o is 0. Both control inputs are expected to be 0 out of reset, which leaves trimming on and coarse steps allowed.
- R2: The measured count is the number of clock cycles from the cycle in which ref_start_i is high to the cycle in which ref_stop_i is high. If start is in cycle 0 and stop is in cycle k, the count is k. The outputs update on the clock edge that samples ref_stop_i.
- R3: Take err = count − 1024. If |err| > 64 and fine_only_i is 0, coarse_o steps by one: down when err > 0 and up when err < 0. On every change of coarse_o, fine_o is reset to 32.
- R4: If 1 < |err| ≤ 64, fine_o steps by one (down for err > 0, up for err < 0) and coarse_o is unchanged. If |err| ≤ 1, neither code changes.
- R5: While fine_only_i is 1, coarse_o never changes. An error with |err| > 64 then steps fine_o by one in the correction direction.
- R6: coarse_o saturates at 0 and 15 without wrapping. When the coarse code is pinned at the limit it would move past, the measurement steps fine_o instead. fine_o saturates at 0 and 63.
- R7: While disable_i is 1, reference events are ignored and the codes and the lock flag stay frozen. A span open when disable_i rises is dropped. A stop that arrives while disable_i is 1 is not acted on after disable_i clears.
- R8: locked_o rises after 3 consecutive measurements with |err| ≤ 15 (1.5% of 1024). It clears on any measurement outside that window.
- R9: Without a completed measurement (no traffic, or a ref_stop_i with no open span), both codes and locked_o hold.
- R10: A ref_start_i that arrives while a span is open restarts the count from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_start_i | input | 1 | One-cycle pulse opening a reference span |
| ref_stop_i | input | 1 | One-cycle pulse closing a reference span |
| disable_i | input | 1 | Freezes trimming and drops reference events |
| fine_only_i | input | 1 | Suppresses coarse steps |
| coarse_o | output | 4 | Coarse trim code |
| fine_o | output | 6 | Fine trim code |
| locked_o | output | 1 | Frequency within ±1.5% for 3 consecutive spans |

## Verification
Every internal fault in this block shows up at the trim codes on the clock edge that closes a span.

- An off-by-one in the span counter shows up at the dead band and the window edges. A count of 1025 must leave the codes alone, and an error of 16 must drop the lock. Either slip changes a code or the flag on that same edge.
- A wrong streak count, or a missed re-centre of the fine code, appears one span later than the cause, as an unexpected flag level or fine value.
- Stale span state left by a disable or a restart appears as a code step where none is expected. This is checked on the edge of the stop pulse that follows.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_COARSE_UP,
    ACT_COARSE_DN,
    ACT_FINE_UP,
    ACT_FINE_DN
  } trim_act_e;

endpackage

// File: rtl/span_counter.sv
module span_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             dis_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (dis_i) begin
      run_q <= 1'b0;          // open span dropped, nothing kept
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q && cnt_q != CntMax) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // count includes the stop cycle itself
  assign vld_o = run_q & stop_i & ~dis_i;
  assign cnt_o = (cnt_q == CntMax) ? CntMax : cnt_q + 1'b1;
endmodule

// File: rtl/trim_decider.sv
module trim_decider
  import osc_trim_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int EXP_CNT    = 1024,
  parameter int COARSE_TOL = 64,
  parameter int FINE_DEAD  = 1,
  parameter int LOCK_TOL   = 15
) (
  input  logic             vld_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fine_only_i,
  input  logic             coarse_max_i,
  input  logic             coarse_min_i,
  output trim_act_e        act_o,
  output logic             in_win_o
);
  localparam int EW = CNT_W + 1;
  localparam logic signed [EW-1:0] ExpS   = EW'(EXP_CNT);
  localparam logic        [EW-1:0] CoarseT = EW'(COARSE_TOL);
  localparam logic        [EW-1:0] DeadT   = EW'(FINE_DEAD);
  localparam logic        [EW-1:0] LockT   = EW'(LOCK_TOL);

  logic signed [EW-1:0] err;
  logic        [EW-1:0] mag;
  logic                 fast;
  logic                 coarse_ok;

  always_comb begin
    err       = $signed({1'b0, cnt_i}) - ExpS;
    fast      = (err > 0);
    mag       = fast ? EW'(err) : EW'(-err);
    coarse_ok = !fine_only_i && (fast ? !coarse_min_i : !coarse_max_i);
    act_o     = ACT_HOLD;
    if (vld_i) begin
      if (mag > CoarseT && coarse_ok) act_o = fast ? ACT_COARSE_DN : ACT_COARSE_UP;
      else if (mag > DeadT)           act_o = fast ? ACT_FINE_DN : ACT_FINE_UP;
    end
    in_win_o = (mag <= LockT);
  end
endmodule

// File: rtl/trim_reg.sv
module trim_reg #(
  parameter int W       = 4,
  parameter int RST_VAL = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         set_i,
  input  logic [W-1:0] set_val_i,
  output logic [W-1:0] q_o,
  output logic         at_max_o,
  output logic         at_min_o
);
  localparam logic [W-1:0] RstV = W'(RST_VAL);
  localparam logic [W-1:0] MaxV = {W{1'b1}};

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= RstV;
    else if (set_i)             q <= set_val_i;
    else if (inc_i && q != MaxV) q <= q + 1'b1;
    else if (dec_i && q != '0)   q <= q - 1'b1;
  end

  assign q_o      = q;
  assign at_max_o = (q == MaxV);
  assign at_min_o = (q == '0);
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
  parameter int LOCK_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic in_win_i,
  output logic locked_o
);
  localparam int SW = $clog2(LOCK_RUN + 1);
  localparam logic [SW-1:0] RunV = SW'(LOCK_RUN);

  logic [SW-1:0] streak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) streak_q <= '0;
    else if (vld_i) begin
      if (!in_win_i)            streak_q <= '0;
      else if (streak_q != RunV) streak_q <= streak_q + 1'b1;
    end
  end

  assign locked_o = (streak_q == RunV);
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int COARSE_W   = 4,
  parameter int FINE_W     = 6,
  parameter int CNT_W      = 12,
  parameter int EXP_CNT    = 1024,
  parameter int COARSE_TOL = 64,
  parameter int FINE_DEAD  = 1,
  parameter int LOCK_PPT   = 15,
  parameter int LOCK_RUN   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_start_i,
  input  logic                ref_stop_i,
  input  logic                disable_i,
  input  logic                fine_only_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic                locked_o
);
  localparam int CoarseMid = 1 << (COARSE_W - 1);
  localparam int FineMid   = 1 << (FINE_W - 1);
  localparam int LockTol   = EXP_CNT * LOCK_PPT / 1000;

  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  trim_act_e        act;
  logic             in_win;
  logic             c_max, c_min, f_max, f_min;
  logic             c_inc, c_dec, c_move;

  span_counter #(.CNT_W(CNT_W)) u_span (
    .clk_i, .rst_ni,
    .start_i (ref_start_i),
    .stop_i  (ref_stop_i),
    .dis_i   (disable_i),
    .vld_o   (meas_vld),
    .cnt_o   (meas_cnt)
  );

  trim_decider #(
    .CNT_W(CNT_W), .EXP_CNT(EXP_CNT), .COARSE_TOL(COARSE_TOL),
    .FINE_DEAD(FINE_DEAD), .LOCK_TOL(LockTol)
  ) u_dec (
    .vld_i        (meas_vld),
    .cnt_i        (meas_cnt),
    .fine_only_i  (fine_only_i),
    .coarse_max_i (c_max),
    .coarse_min_i (c_min),
    .act_o        (act),
    .in_win_o     (in_win)
  );

  assign c_inc  = (act == ACT_COARSE_UP);
  assign c_dec  = (act == ACT_COARSE_DN);
  assign c_move = c_inc | c_dec;  // decider already excludes pinned limits

  trim_reg #(.W(COARSE_W), .RST_VAL(CoarseMid)) u_coarse (
    .clk_i, .rst_ni,
    .inc_i     (c_inc),
    .dec_i     (c_dec),
    .set_i     (1'b0),
    .set_val_i ('0),
    .q_o       (coarse_o),
    .at_max_o  (c_max),
    .at_min_o  (c_min)
  );

  trim_reg #(.W(FINE_W), .RST_VAL(FineMid)) u_fine (
    .clk_i, .rst_ni,
    .inc_i     (act == ACT_FINE_UP),
    .dec_i     (act == ACT_FINE_DN),
    .set_i     (c_move),
    .set_val_i (FINE_W'(FineMid)),
    .q_o       (fine_o),
    .at_max_o  (f_max),
    .at_min_o  (f_min)
  );

  lock_tracker #(.LOCK_RUN(LOCK_RUN)) u_lock (
    .clk_i, .rst_ni,
    .vld_i    (meas_vld),
    .in_win_i (in_win),
    .locked_o (locked_o)
  );

  logic unused_flags;
  assign unused_flags = f_max ^ f_min;
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ref_start_i,
  input logic                ref_stop_i,
  input logic                disable_i,
  input logic                fine_only_i,
  input logic [COARSE_W-1:0] coarse_o,
  input logic [FINE_W-1:0]   fine_o,
  input logic                locked_o
);
  localparam logic [FINE_W-1:0] FineMid = FINE_W'(1 << (FINE_W - 1));

  logic unused_start;
  assign unused_start = ref_start_i;

  AST_COARSE_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(coarse_o) - int'($past(coarse_o)) <= 1) &&
    (int'($past(coarse_o)) - int'(coarse_o) <= 1)); // R3

  AST_FINE_RECENTRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(coarse_o) |-> fine_o == FineMid); // R3

  AST_FINE_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(coarse_o) |-> (int'(fine_o) - int'($past(fine_o)) <= 1) &&
                          (int'($past(fine_o)) - int'(fine_o) <= 1)); // R4

  AST_FINE_ONLY_COARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fine_only_i) |-> $stable(coarse_o)); // R5

  AST_DISABLE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(disable_i) |-> $stable(coarse_o) && $stable(fine_o) && $stable(locked_o)); // R7

  AST_LOCK_ON_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(ref_stop_i)); // R8

  AST_HOLD_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_stop_i) |-> $stable(coarse_o) && $stable(fine_o) && $stable(locked_o)); // R9
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_start_i(ref_start_i), .ref_stop_i(ref_stop_i),
  .disable_i(disable_i), .fine_only_i(fine_only_i),
  .coarse_o(coarse_o), .fine_o(fine_o), .locked_o(locked_o)
);

// File: tb/sim_osc_trim_ctrl.sv
`timescale 1ns/1ps
module sim_osc_trim_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, dis = 1'b0, fo = 1'b0;
  logic [3:0] coarse;
  logic [5:0] fine;
  logic       locked;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  osc_trim_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_start_i(start), .ref_stop_i(stop),
    .disable_i(dis), .fine_only_i(fo),
    .coarse_o(coarse), .fine_o(fine), .locked_o(locked)
  );

  localparam int NV = 10;
  // fine_only, span count, expected coarse, fine, locked
  localparam int V_FO [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
  localparam int V_CNT[NV] = '{1200, 900, 1050, 1010, 1024, 1025, 1040, 1300, 700, 1023};
  localparam int V_C  [NV] = '{7, 8, 8, 8, 8, 8, 8, 8, 8, 8};
  localparam int V_F  [NV] = '{32, 32, 31, 32, 32, 32, 31, 30, 31, 31};
  localparam int V_L  [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0};

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, int c, int f, int l);
    chk(req, coarse, c);
    chk(req, fine, f);
    chk(req, locked, l);
  endtask

  // start in cycle 0, stop in cycle k; returns at the negedge after the stop edge
  task automatic span(int k);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (k - 1) @(negedge clk);
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 8, 32, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release", 8, 32, 0);

    // R2 R3 R4 R5 R8: table walk
    for (int i = 0; i < NV; i++) begin
      fo = V_FO[i][0];
      span(V_CNT[i]);
      chk_all($sformatf("R2 R3 R4 R5 R8 vec %0d", i), V_C[i], V_F[i], V_L[i]);
    end
    fo = 1'b0;

    // R6 coarse pinned high, then fine takes the step
    for (int i = 0; i < 7; i++) span(700);
    chk_all("R6 coarse reaches 15", 15, 32, 0);
    span(700);
    chk_all("R6 coarse pinned, fine steps", 15, 33, 0);

    // R6 fine floor, R8 lock on small error
    fo = 1'b1;
    for (int i = 0; i < 34; i++) span(1030);
    chk_all("R6 fine saturates at 0", 15, 0, 1);
    fo = 1'b0;

    // R6 coarse floor
    for (int i = 0; i < 15; i++) span(1200);
    chk_all("R6 coarse reaches 0", 0, 32, 0);
    span(1200);
    chk_all("R6 coarse pinned low, fine steps", 0, 31, 0);

    // R10 restart mid span: counted from second start, 1024 -> no step
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (500) @(negedge clk);
    span(1024);
    chk_all("R10 restart", 0, 31, 0);
    span(1024);
    span(1024);
    chk_all("R8 locked after 3", 0, 31, 1);

    // R9 idle and stray stop
    repeat (3000) @(negedge clk);
    chk_all("R9 idle hold", 0, 31, 1);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk_all("R9 stray stop", 0, 31, 1);

    // R7 disabled span ignored
    dis = 1'b1;
    span(1200);
    chk_all("R7 disabled span", 0, 31, 1);
    // R7 span opened while disabled, closed after enable
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    dis = 1'b0;
    repeat (5) @(negedge clk);
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk_all("R7 no queued event", 0, 31, 1);
    // R7 stop during disable not applied later
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (1300) @(negedge clk);
    dis = 1'b1;
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    dis = 1'b0;
    repeat (5) @(negedge clk);
    chk_all("R7 stop while disabled", 0, 31, 1);

    // R1 reset mid operation
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 re-reset", 8, 32, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule